// File: doc/BRIEF.md
# Fuse Strobe Sequencer

This block times the strobes that read or blow one 32-bit word of a one-time-programmable fuse array. A controller hands it a start pulse, a mode (read or program), the word to program (already masked against bits that are blown), and a packed timing word whose fields are counted in clock cycles. The block copies the timing fields at start and runs the pulse sequence. It then raises a one-cycle completion flag.

In program mode the word goes into a shift register that moves right with zero fill, one bit per step, starting at the LSB. A step whose current bit is 1 runs a guard interval, a program strobe and a second guard interval, with a per-bit enable held high across all three. A step whose bit is 0 takes a single cycle and fires no strobe. In read mode one guard, a read strobe and one guard are run, and the parallel fuse word is captured during the last strobe cycle.

Top module: `fuse_strobe_timer`

## Requirements
- R1: While reset is held and whenever the block is idle, `fuse_strobe`, `bit_en`, `ser_bit`, `busy` and `done` are low. `rd_word` resets to zero.
- R2: With the default layout, the timing word holds the program strobe length in bits [11:0], the guard length in bits [15:12] and the read strobe length in bits [21:16]. All three fields are copied when an operation starts, so later changes to `timing_cfg` have no effect on that operation.
- R3: Every strobe has a guard interval of exactly G+1 cycles before it and G+1 cycles after it, where G is the guard field. In program mode `bit_en` is high for the whole guard–strobe–guard window of a bit.
- R4: A strobe lasts exactly N cycles, where N is the program or read strobe field. A field value of 0 gives a strobe of one cycle.
- R5: Program bits are handled LSB first. `ser_bit` shows the current LSB of the shift register, which moves right by one with zero fill in a one-cycle shift step taken after each bit. `bit_en` is low during that step.
- R6: A program bit equal to 0 produces no strobe and takes only the one-cycle shift step. The number of program strobes never exceeds 32.
- R7: `busy` rises in the cycle after an accepted start and stays high through the cycle in which `done` is high. `done` is a one-cycle pulse after the last of the 32 bits, or after the read's closing guard, and the block is idle in the next cycle.
- R8: A read runs guard, read strobe and guard. `rd_word` takes the value of `fuse_rdata` during the last strobe cycle and holds it until the next read.
- R9: A start that arrives while `busy` is high, or in the `done` cycle, is ignored and the running operation goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timing_cfg | input | 32 | Packed timing word (guard, program and read strobe lengths) |
| start | input | 1 | Start request, accepted only when idle |
| prog_mode | input | 1 | 1 = program the word, 0 = read |
| prog_word | input | 32 | Masked word to program, LSB first |
| fuse_rdata | input | 32 | Parallel word from the fuse array |
| fuse_strobe | output | 1 | Strobe to the fuse array |
| bit_en | output | 1 | Enable for the bit being programmed |
| ser_bit | output | 1 | Current serial program bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | 32 | Last captured read word |

## Verification
The bound checker watches several rules on every cycle. The idle outputs must stay quiet, `bit_en` may be high only on a 1 bit, and each strobe must have busy guard cycles on both sides. `done` must be a single pulse followed by idle, and no operation may have more than 32 strobes. Only the bench scenarios can show the exact lengths taken from each field and the zero-means-one rule. The same holds for the bit order and zero fill, which fields are sampled at start, capture timing on reads, and that a start or a timing change in the middle of an operation leaves it unchanged. For these the bench compares every output on every clock against a trace it builds itself.

// File: rtl/fst_pkg.sv
// Shared types for the fuse strobe sequencer.
package fst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_STB,
        ST_POST,
        ST_SHIFT,
        ST_FIN
    } fst_state_e;
endpackage

// File: rtl/fst_cfg_decode.sv
// Unpacks the timing word into counter load values (length minus one).
// Assumes CNT_W is wide enough for the widest field (12 bits).
// ALT_LAYOUT=0: prog [11:0], guard [15:12], read [21:16].
// ALT_LAYOUT=1: prog [11:0], source-enable guard [19:12], read reuses prog.
module fst_cfg_decode #(
    parameter int CFG_W      = 32,
    parameter int CNT_W      = 12,
    parameter int ALT_LAYOUT = 0
) (
    input  logic [CFG_W-1:0] cfg,
    output logic [CNT_W-1:0] guard_ld,
    output logic [CNT_W-1:0] prog_ld,
    output logic [CNT_W-1:0] read_ld
);
    localparam int PROG_W = 12;

    logic [PROG_W-1:0] prog_f;
    assign prog_f = cfg[PROG_W-1:0];

    // A zero strobe field still gives one cycle.
    assign prog_ld = (prog_f == '0) ? '0 : CNT_W'(prog_f - 1'b1);

    generate
        if (ALT_LAYOUT == 0) begin : g_std
            logic [3:0] guard_f;
            logic [5:0] read_f;
            logic       unused_hi;
            assign guard_f   = cfg[15:12];
            assign read_f    = cfg[21:16];
            assign unused_hi = ^cfg[CFG_W-1:22];
            assign guard_ld  = CNT_W'(guard_f);
            assign read_ld   = (read_f == '0) ? '0 : CNT_W'(read_f - 1'b1);
        end else begin : g_alt
            logic [7:0] guard_f;
            logic       unused_hi;
            assign guard_f   = cfg[19:12];
            assign unused_hi = ^cfg[CFG_W-1:20];
            assign guard_ld  = CNT_W'(guard_f);
            assign read_ld   = prog_ld;
        end
    endgenerate
endmodule

// File: rtl/fst_phase_cnt.sv
// Down counter for one phase: loaded with length-1, flags zero on the
// final cycle of the phase. Holds at zero when not loaded.
module fst_phase_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             is_zero
);
    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/fst_shifter.sv
// Program data register: parallel load, right shift with zero fill.
module fst_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic [W-1:0] q
);
    // Load has priority over shift.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (load)   q <= load_val;
        else if (shift)  q <= {1'b0, q[W-1:1]};
    end
endmodule

// File: rtl/fuse_strobe_timer.sv
// Fuse strobe sequencer top. Runs guard/strobe/guard around each 1 bit
// of the program word (LSB first) or around one read strobe.
// Assumes prog_word is already masked and fuse_rdata is stable while
// the read strobe is high. BITS must be at least 2.
module fuse_strobe_timer #(
    parameter int BITS       = 32,
    parameter int CFG_W      = 32,
    parameter int CNT_W      = 12,
    parameter int ALT_LAYOUT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CFG_W-1:0] timing_cfg,
    input  logic            start,
    input  logic            prog_mode,
    input  logic [BITS-1:0] prog_word,
    input  logic [BITS-1:0] fuse_rdata,
    output logic            fuse_strobe,
    output logic            bit_en,
    output logic            ser_bit,
    output logic            busy,
    output logic            done,
    output logic [BITS-1:0] rd_word
);
    import fst_pkg::*;

    localparam int IDX_W = $clog2(BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS - 1);

    fst_state_e       st_q, st_d;
    logic             mode_q;
    logic [CNT_W-1:0] guard_q, sprog_q, sread_q;
    logic [CNT_W-1:0] dec_guard, dec_prog, dec_read;
    logic [IDX_W-1:0] idx_q;
    logic [BITS-1:0]  sh_q;
    logic             cnt_ld, cnt_zero, sh_ld, sh_en, cfg_ld, cap_en;
    logic [CNT_W-1:0] cnt_val;
    logic [BITS-1:0]  sh_val;

    fst_cfg_decode #(.CFG_W(CFG_W), .CNT_W(CNT_W), .ALT_LAYOUT(ALT_LAYOUT)) dec_i (
        .cfg(timing_cfg), .guard_ld(dec_guard), .prog_ld(dec_prog), .read_ld(dec_read)
    );

    fst_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(cnt_ld), .load_val(cnt_val), .is_zero(cnt_zero)
    );

    fst_shifter #(.W(BITS)) sh_i (
        .clk(clk), .rst_n(rst_n), .load(sh_ld), .load_val(sh_val), .shift(sh_en), .q(sh_q)
    );

    // Next-state and phase-load decisions.
    always_comb begin
        st_d    = st_q;
        cnt_ld  = 1'b0;
        cnt_val = '0;
        sh_ld   = 1'b0;
        sh_val  = '0;
        sh_en   = 1'b0;
        cfg_ld  = 1'b0;
        cap_en  = 1'b0;
        unique case (st_q)
            ST_IDLE: if (start) begin
                cfg_ld  = 1'b1;
                sh_ld   = 1'b1;
                sh_val  = prog_mode ? prog_word : '0;
                cnt_ld  = 1'b1;
                cnt_val = dec_guard;
                st_d    = (prog_mode && !prog_word[0]) ? ST_SHIFT : ST_PRE;
            end
            ST_PRE: if (cnt_zero) begin
                cnt_ld  = 1'b1;
                cnt_val = mode_q ? sprog_q : sread_q;
                st_d    = ST_STB;
            end
            ST_STB: if (cnt_zero) begin
                cnt_ld  = 1'b1;
                cnt_val = guard_q;
                cap_en  = !mode_q;
                st_d    = ST_POST;
            end
            ST_POST: if (cnt_zero) st_d = mode_q ? ST_SHIFT : ST_FIN;
            ST_SHIFT: begin
                sh_en = 1'b1;
                if (idx_q == LAST_IDX) begin
                    st_d = ST_FIN;
                end else if (sh_q[1]) begin
                    cnt_ld  = 1'b1;
                    cnt_val = guard_q;
                    st_d    = ST_PRE;
                end
            end
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State, captured fields, bit index and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            mode_q  <= 1'b0;
            guard_q <= '0;
            sprog_q <= '0;
            sread_q <= '0;
            idx_q   <= '0;
            rd_word <= '0;
        end else begin
            st_q <= st_d;
            if (cfg_ld) begin
                mode_q  <= prog_mode;
                guard_q <= dec_guard;
                sprog_q <= dec_prog;
                sread_q <= dec_read;
                idx_q   <= '0;
            end else if (sh_en) begin
                idx_q <= idx_q + 1'b1;
            end
            if (cap_en) rd_word <= fuse_rdata;
        end
    end

    assign fuse_strobe = (st_q == ST_STB);
    assign bit_en      = mode_q && (st_q == ST_PRE || st_q == ST_STB || st_q == ST_POST);
    assign ser_bit     = sh_q[0];
    assign busy        = (st_q != ST_IDLE);
    assign done        = (st_q == ST_FIN);
endmodule

// File: rtl/fuse_strobe_timer_chk.sv
// Cycle rules for the fuse strobe sequencer, bound to its top.
module fuse_strobe_timer_chk #(
    parameter int BITS = 32
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic fuse_strobe,
    input logic bit_en,
    input logic ser_bit,
    input logic busy,
    input logic done
);
    logic [7:0] n_stb_q;

    // Strobe rises counted per operation.
    always_ff @(posedge clk) begin
        if (!rst_n || done)                  n_stb_q <= '0;
        else if (fuse_strobe && !bit_en) n_stb_q <= n_stb_q;
        else if ($rose(fuse_strobe))     n_stb_q <= n_stb_q + 1'b1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fuse_strobe && !bit_en && !ser_bit && !done));

    p_guard_before_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fuse_strobe) |-> ($past(busy) && !$past(fuse_strobe)));

    p_guard_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_strobe) |-> (busy && !done));

    p_enable_on_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> ser_bit);

    p_strobe_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        n_stb_q <= 8'(BITS));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_start_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind fuse_strobe_timer fuse_strobe_timer_chk #(.BITS(BITS)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fuse_strobe(fuse_strobe),
    .bit_en(bit_en), .ser_bit(ser_bit), .busy(busy), .done(done)
);

// File: tb/fuse_strobe_timer_tb_top.sv
// Bench: builds the expected per-cycle output trace for each operation
// and compares every output at each falling edge.
module fuse_strobe_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_cfg = '0;
    logic        start = 1'b0;
    logic        prog_mode = 1'b0;
    logic [31:0] prog_word = '0;
    logic [31:0] fuse_rdata = '0;
    logic        fuse_strobe, bit_en, ser_bit, busy, done;
    logic [31:0] rd_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_strobe_timer dut_i (
        .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg), .start(start),
        .prog_mode(prog_mode), .prog_word(prog_word), .fuse_rdata(fuse_rdata),
        .fuse_strobe(fuse_strobe), .bit_en(bit_en), .ser_bit(ser_bit),
        .busy(busy), .done(done), .rd_word(rd_word)
    );

    typedef struct {
        bit stb; bit en; bit ser; bit bsy; bit dn; bit cap;
    } ent_t;

    ent_t        q[$];
    int          vectors = 0;
    int          miscompares = 0;
    bit          cur_idle = 1'b1;
    logic [31:0] exp_rd = '0;
    logic [31:0] cap_val = '0;
    string       tag = "R1";

    function automatic ent_t mk(bit s, bit e, bit r, bit b, bit d, bit c);
        ent_t x;
        x.stb = s; x.en = e; x.ser = r; x.bsy = b; x.dn = d; x.cap = c;
        return x;
    endfunction

    // Expected trace for one accepted start, from the requirement text.
    task automatic build(input logic [31:0] cfg, input bit pm,
                         input logic [31:0] w, input logic [31:0] fr);
        int g  = int'(cfg[15:12]) + 1;
        int sp = (cfg[11:0] == 0) ? 1 : int'(cfg[11:0]);
        int sr = (cfg[21:16] == 0) ? 1 : int'(cfg[21:16]);
        if (pm) begin
            for (int i = 0; i < 32; i++) begin
                logic [31:0] d = w >> i;
                if (d[0]) begin
                    for (int k = 0; k < g; k++)  q.push_back(mk(0, 1, 1, 1, 0, 0));
                    for (int k = 0; k < sp; k++) q.push_back(mk(1, 1, 1, 1, 0, 0));
                    for (int k = 0; k < g; k++)  q.push_back(mk(0, 1, 1, 1, 0, 0));
                end
                q.push_back(mk(0, 0, d[0], 1, 0, 0));
            end
        end else begin
            cap_val = fr;
            for (int k = 0; k < g; k++)  q.push_back(mk(0, 0, 0, 1, 0, 0));
            for (int k = 0; k < sr; k++) q.push_back(mk(1, 0, 0, 1, 0, 0));
            for (int k = 0; k < g; k++)  q.push_back(mk(0, 0, 0, 1, 0, (k == 0)));
        end
        q.push_back(mk(0, 0, 0, 1, 1, 0));
    endtask

    task automatic chk1(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
        end
    endtask

    // One clock: compare all outputs against the next trace entry.
    task automatic cycle();
        ent_t e;
        @(negedge clk);
        if (q.size() > 0) begin
            e = q.pop_front();
            cur_idle = 1'b0;
        end else begin
            e = mk(0, 0, 0, 0, 0, 0);
            cur_idle = 1'b1;
        end
        if (e.cap) exp_rd = cap_val;
        chk1("strobe(R4)", 32'(fuse_strobe), 32'(e.stb));
        chk1("bit_en(R3)", 32'(bit_en), 32'(e.en));
        chk1("ser_bit(R5)", 32'(ser_bit), 32'(e.ser));
        chk1("busy(R7)", 32'(busy), 32'(e.bsy));
        chk1("done(R7)", 32'(done), 32'(e.dn));
        chk1("rd_word(R8)", rd_word, exp_rd);
    endtask

    task automatic issue(input logic [31:0] cfg, input bit pm,
                         input logic [31:0] w, input logic [31:0] fr);
        timing_cfg = cfg; prog_mode = pm; prog_word = w; fuse_rdata = fr;
        start = 1'b1;
        if (cur_idle) build(cfg, pm, w, fr);
        cycle();
        start = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) cycle();
        cycle();
        cycle();
    endtask

    function automatic logic [31:0] tcfg(int rd, int g, int pg);
        return {10'b0, 6'(rd), 4'(g), 12'(pg)};
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL R7 watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        // R1: reset state, including while reset is still held.
        repeat (2) @(posedge clk);
        tag = "R1";
        cycle();
        cycle();
        rst_n = 1'b1;
        cycle();

        // R2 R3 R4 R5: two 1 bits, guard field 2, program strobe 3.
        tag = "R3";
        issue(tcfg(4, 2, 3), 1'b1, 32'h0000_0005, '0);
        drain();

        // R6: all-zero word gives 32 single shift cycles, no strobe.
        tag = "R6";
        issue(tcfg(4, 1, 2), 1'b1, 32'h0000_0000, '0);
        drain();

        // R4: zero program field means one cycle; R5: LSB and MSB only.
        tag = "R4";
        issue(tcfg(0, 0, 0), 1'b1, 32'h8000_0001, '0);
        drain();

        // R8: read with read field 5, guard 1.
        tag = "R8";
        issue(tcfg(5, 1, 7), 1'b0, '0, 32'hA5C3_0F96);
        drain();

        // R8 R4: read with read field 0, guard 0.
        tag = "R8";
        issue(tcfg(0, 0, 9), 1'b0, '0, 32'h1234_5678);
        drain();

        // R9 R2: start and timing change in mid-operation are ignored.
        tag = "R9";
        issue(tcfg(3, 1, 2), 1'b1, 32'h0000_0006, '0);
        repeat (3) cycle();
        issue(tcfg(9, 7, 11), 1'b1, 32'hFFFF_0000, '0);
        timing_cfg = tcfg(1, 9, 13);
        drain();

        // R9: start in the done cycle is dropped.
        tag = "R9";
        issue(tcfg(2, 0, 1), 1'b0, '0, 32'h0BAD_F00D);
        while (q.size() > 1) cycle();
        cycle();
        issue(tcfg(2, 0, 1), 1'b1, 32'hFFFF_FFFF, '0);
        drain();

        // R5 R6: every bit set, shortest timings.
        tag = "R5";
        issue(tcfg(0, 0, 1), 1'b1, 32'hFFFF_FFFF, '0);
        drain();

        // R2: field bits above [21:16] do not alter timing.
        tag = "R2";
        issue(32'hFFC0_0000 | tcfg(2, 1, 2), 1'b1, 32'h0000_0102, '0);
        drain();

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule